// File: doc/BRIEF.md
# Sequential Multi-Stage Parallel Trigger

This block watches an 8-bit parallel sample stream and decides when a logic capture should begin. Four trigger stages are held inside it. Each stage has a bit mask, a compare value, a sample delay, the trigger level at which it may take part, and a flag that says whether firing it starts the capture. The samples are judged one at a time, on the same sample-enable strobe that a capture memory would use to store them.

A stage can only fire once the trigger level has climbed to its own level. Firing a stage raises the level by one, so stages are passed through one after another rather than in any order. A stage may also hold its effect back for a given number of further samples. When a stage with the start flag completes, the block gives a one-cycle capture-start pulse and then ignores the stream until it is armed again. Software writes the stage settings through a small addressed write port and arms the block with a single-cycle strobe.

Top module: `seq_trigger`

## Requirements
- R1: After reset the block is not armed: start_o is 0 and no sample produces a start until arm_i has been pulsed.
- R2: A stage's sample test passes when (sample_i AND mask) equals (value AND mask), bit by bit. A mask of 0 passes every sample.
- R3: A write with cfg_we_i high stores cfg_wdata_i into the stage chosen by cfg_stage_i. cfg_sel_i picks the field: 0 = mask (bits 7:0), 1 = value (bits 7:0), 2 = config word (delay in bits 15:0, level in bits 17:16, start flag in bit 24). cfg_sel_i = 3 changes nothing, and no write reaches any other stage.
- R4: Arming sets the current level to 0. A stage takes part only while its level equals the current level. Firing a stage raises the current level by exactly 1.
- R5: If several stages take part and pass on the same sample, the stage with the lowest index is the one taken.
- R6: A stage whose start flag is 0 raises the level when it fires but produces no start.
- R7: A taken stage with delay D fires on the same sample if D is 0. Otherwise it fires on the D-th later sample-enable, whatever those samples hold. Clock cycles without sample_en_i do not count.
- R8: While a delay is counting, no stage is taken, even if it would pass.
- R9: start_o is high for exactly one clock cycle, in the cycle that follows the clock edge at which the firing sample was enabled.
- R10: After a start the block ignores all samples until it is re-armed. Arming also drops a delay that is still counting and returns the level to 0. arm_i wins over a sample-enable in the same cycle.
- R11: Cycles with sample_en_i low change no trigger state and never produce a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm strobe: clears level and delay, enables triggering |
| sample_en_i | input | 1 | Sample strobe; one trigger evaluation per high cycle |
| sample_i | input | 8 | Parallel sample data |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_stage_i | input | 2 | Target stage of the write |
| cfg_sel_i | input | 2 | Field select: 0 mask, 1 value, 2 config word, 3 none |
| cfg_wdata_i | input | 32 | Write data |
| start_o | output | 1 | One-cycle capture-start pulse |

## Verification
The compare rule is swept over all 256 sample values under several masks. This separates masked bits from compared bits and covers the case where a zero mask passes everything. Fixed scenarios feed the stages their values out of order, put two stages on the same level, insert idle cycles inside delays, and re-arm in the middle of a delay. Each scenario isolates ordering, priority, delay counting or arm clearing. A long pseudo-random run then uses narrow masks and short delays, so that hits, overlaps and pending delays happen often. Every sample there is compared with a behavioural model built from the requirements.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;
  localparam int unsigned NUM_STAGES = 4;
  localparam int unsigned STG_W      = $clog2(NUM_STAGES);
  localparam int unsigned LVL_W      = $clog2(NUM_STAGES);
  localparam int unsigned DELAY_W    = 16;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned ACT_BIT    = 24;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CFG   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic               action;
    logic [LVL_W-1:0]   level;
    logic [DELAY_W-1:0] delay;
  } stage_cfg_t;
endpackage

// File: rtl/seq_trig_stage.sv
module seq_trig_stage
  import seq_trig_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [STG_W-1:0]  cfg_stage_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [LVL_W:0]    cur_lvl_i,
  output logic              hit_o,
  output stage_cfg_t        cfg_o
);
  logic [DATA_W-1:0] mask_q, value_q;
  stage_cfg_t        cfg_q;
  logic              wr_sel;

  assign wr_sel = cfg_we_i && (cfg_stage_i == STG_W'(IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      value_q <= '0;
      cfg_q   <= '0;
    end else if (wr_sel) begin
      case (cfg_sel_e'(cfg_sel_i))
        SEL_MASK:  mask_q  <= cfg_wdata_i[DATA_W-1:0];
        SEL_VALUE: value_q <= cfg_wdata_i[DATA_W-1:0];
        SEL_CFG: begin
          cfg_q.delay  <= cfg_wdata_i[DELAY_W-1:0];
          cfg_q.level  <= cfg_wdata_i[DELAY_W +: LVL_W];
          cfg_q.action <= cfg_wdata_i[ACT_BIT];
        end
        default: ;
      endcase
    end
  end

  // masked compare, gated by level qualification
  assign hit_o = (((sample_i ^ value_q) & mask_q) == '0) &&
                 (cur_lvl_i == {1'b0, cfg_q.level});
  assign cfg_o = cfg_q;
endmodule

// File: rtl/seq_trig_seq.sv
module seq_trig_seq
  import seq_trig_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            arm_i,
  input  logic                            sample_en_i,
  input  logic [NUM_STAGES-1:0]           hit_i,
  input  stage_cfg_t [NUM_STAGES-1:0]     cfg_i,
  output logic [LVL_W:0]                  cur_lvl_o,
  output logic                            armed_o,
  output logic                            pend_o,
  output logic [DELAY_W-1:0]              cnt_o,
  output logic                            start_o
);
  logic [LVL_W:0]     lvl_q;
  logic               armed_q, pend_q, start_q;
  logic [DELAY_W-1:0] cnt_q;
  logic [STG_W-1:0]   pend_idx_q;

  logic               sel_hit;
  logic [STG_W-1:0]   sel_idx;
  logic               step, fire;
  logic [STG_W-1:0]   fire_idx;

  // lowest index wins
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = NUM_STAGES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_hit = 1'b1;
        sel_idx = STG_W'(i);
      end
    end
  end

  assign step = sample_en_i && armed_q && !arm_i;

  always_comb begin
    if (pend_q) begin
      fire     = step && (cnt_q == DELAY_W'(1));
      fire_idx = pend_idx_q;
    end else begin
      fire     = step && sel_hit && (cfg_i[sel_idx].delay == '0);
      fire_idx = sel_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= '0;
      armed_q    <= 1'b0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      pend_idx_q <= '0;
      start_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (arm_i) begin
        lvl_q   <= '0;
        armed_q <= 1'b1;
        pend_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (fire) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
        lvl_q  <= lvl_q + 1'b1;
        if (cfg_i[fire_idx].action) begin
          start_q <= 1'b1;
          armed_q <= 1'b0;
        end
      end else if (step) begin
        if (pend_q) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (sel_hit) begin
          pend_q     <= 1'b1;
          cnt_q      <= cfg_i[sel_idx].delay;
          pend_idx_q <= sel_idx;
        end
      end
    end
  end

  assign cur_lvl_o = lvl_q;
  assign armed_o   = armed_q;
  assign pend_o    = pend_q;
  assign cnt_o     = cnt_q;
  assign start_o   = start_q;
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger
  import seq_trig_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              sample_en_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              cfg_we_i,
  input  logic [STG_W-1:0]  cfg_stage_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              start_o
);
  logic [NUM_STAGES-1:0]       hit;
  stage_cfg_t [NUM_STAGES-1:0] stage_cfg;
  logic [LVL_W:0]              cur_lvl;
  logic                        armed, pend;
  logic [DELAY_W-1:0]          cnt;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    seq_trig_stage #(
      .DATA_W (DATA_W),
      .IDX    (g)
    ) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i),
      .cfg_stage_i (cfg_stage_i),
      .cfg_sel_i   (cfg_sel_i),
      .cfg_wdata_i (cfg_wdata_i),
      .sample_i    (sample_i),
      .cur_lvl_i   (cur_lvl),
      .hit_o       (hit[g]),
      .cfg_o       (stage_cfg[g])
    );
  end

  seq_trig_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .sample_en_i (sample_en_i),
    .hit_i       (hit),
    .cfg_i       (stage_cfg),
    .cur_lvl_o   (cur_lvl),
    .armed_o     (armed),
    .pend_o      (pend),
    .cnt_o       (cnt),
    .start_o     (start_o)
  );
endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk
  import seq_trig_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               arm_i,
  input logic               sample_en_i,
  input logic               start_o,
  input logic               armed,
  input logic               pend,
  input logic [LVL_W:0]     cur_lvl,
  input logic [DELAY_W-1:0] cnt
);
  // R9
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R11
  start_needs_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(sample_en_i));

  // R10
  disarm_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !armed);

  // R4
  level_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (cur_lvl == $past(cur_lvl)) || (cur_lvl == $past(cur_lvl) + 1'b1));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_en_i && !arm_i) |=> ($stable(cur_lvl) && $stable(cnt) && $stable(pend)));

  // R10
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (cur_lvl == '0) && !pend && armed && !start_o);
endmodule

bind seq_trigger seq_trigger_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .sample_en_i (sample_en_i),
  .start_o     (start_o),
  .armed       (armed),
  .pend        (pend),
  .cur_lvl     (cur_lvl),
  .cnt         (cnt)
);

// File: tb/tb_seq_trigger.sv
module tb_seq_trigger;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic        sample_en_i = 1'b0;
  logic [7:0]  sample_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_stage_i = '0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        start_o;

  int n_chk = 0;
  int n_err = 0;

  // shadow config and reference model state
  logic [7:0]  sh_mask [4];
  logic [7:0]  sh_val  [4];
  int          sh_dly  [4];
  int          sh_lvl  [4];
  logic        sh_act  [4];
  logic        m_armed = 1'b0;
  int          m_lvl = 0;
  logic        m_pend = 1'b0;
  int          m_cnt = 0;
  int          m_idx = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  seq_trigger dut (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: start_o=%0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic wr(input int s, input int sel, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_stage_i = 2'(s); cfg_sel_i = 2'(sel); cfg_wdata_i = d;
    @(posedge clk_i); #1;
    @(negedge clk_i); cfg_we_i = 1'b0;
    case (sel)
      0: sh_mask[s] = d[7:0];
      1: sh_val[s]  = d[7:0];
      2: begin sh_dly[s] = int'(d[15:0]); sh_lvl[s] = int'(d[17:16]); sh_act[s] = d[24]; end
      default: ;
    endcase
  endtask

  task automatic set_stage(input int s, input logic [7:0] m, input logic [7:0] v,
                           input int dly, input int lvl, input logic act);
    wr(s, 0, {24'h0, m});
    wr(s, 1, {24'h0, v});
    wr(s, 2, {7'h0, act, 6'h0, 2'(lvl), 16'(dly)});
  endtask

  task automatic arm();
    arm_i = 1'b1;
    @(posedge clk_i); #1;
    chk(start_o, 1'b0, "R10 arm gives no start");
    @(negedge clk_i); arm_i = 1'b0;
    m_armed = 1'b1; m_lvl = 0; m_pend = 1'b0; m_cnt = 0;
  endtask

  task automatic model_step(input logic [7:0] d, output logic st);
    int f;
    st = 1'b0;
    f = -1;
    if (!m_armed) return;
    if (m_pend) begin
      m_cnt--;
      if (m_cnt == 0) f = m_idx;
    end else begin
      for (int s = 3; s >= 0; s--)
        if (sh_lvl[s] == m_lvl && ((d ^ sh_val[s]) & sh_mask[s]) == 8'h00) m_idx = s;
      for (int s = 0; s < 4; s++)
        if (sh_lvl[s] == m_lvl && ((d ^ sh_val[s]) & sh_mask[s]) == 8'h00) begin
          if (sh_dly[s] == 0) f = s;
          else begin m_pend = 1'b1; m_cnt = sh_dly[s]; m_idx = s; end
          break;
        end
    end
    if (f >= 0) begin
      m_pend = 1'b0;
      m_lvl++;
      if (sh_act[f]) begin st = 1'b1; m_armed = 1'b0; end
    end
  endtask

  task automatic smp(input logic [7:0] d, input string tag);
    logic e;
    sample_en_i = 1'b1; sample_i = d;
    @(posedge clk_i); #1;
    model_step(d, e);
    chk(start_o, e, tag);
    @(negedge clk_i); sample_en_i = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      sample_i = rnd()[7:0];
      @(posedge clk_i); #1;
      chk(start_o, 1'b0, tag);
      @(negedge clk_i);
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      sh_mask[s] = '0; sh_val[s] = '0; sh_dly[s] = 0; sh_lvl[s] = 0; sh_act[s] = 1'b0;
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #1 chk(start_o, 1'b0, "R1 reset value");
    @(negedge clk_i);

    // R1: not armed after reset, even with a stage that would start
    set_stage(0, 8'h00, 8'h00, 0, 0, 1'b1);
    smp(8'h00, "R1 disarmed after reset");
    smp(8'hFF, "R1 disarmed after reset");

    // R2: exhaustive compare sweep on stage 0; other stages parked at level 3
    for (int s = 1; s < 4; s++) set_stage(s, 8'hFF, 8'h00, 0, 3, 1'b1);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] m;
      m = (k == 0) ? 8'h00 : (k == 1) ? 8'hF0 : 8'h5A;
      set_stage(0, m, 8'hC3, 0, 0, 1'b1);
      for (int v = 0; v < 256; v++) begin
        arm();
        smp(8'(v), "R2 masked compare");
      end
    end

    // R3: field 3 and writes to other stages leave stage 0 intact
    set_stage(0, 8'hFF, 8'h5A, 0, 0, 1'b1);
    wr(0, 3, 32'h0000_0000);
    wr(1, 1, 32'h0000_0011);
    wr(2, 0, 32'h0000_0000);
    arm();
    smp(8'h00, "R3 no stray write");
    smp(8'h5A, "R3 value kept");
    arm();
    wr(1, 2, {7'h0, 1'b1, 6'h0, 2'd0, 16'd0});
    wr(1, 0, 32'h0000_00FF);
    smp(8'h11, "R3 stage 1 written");

    // R4/R6: four levels, fed out of order
    set_stage(0, 8'hFF, 8'h11, 0, 0, 1'b0);
    set_stage(1, 8'hFF, 8'h22, 0, 1, 1'b0);
    set_stage(2, 8'hFF, 8'h33, 0, 2, 1'b0);
    set_stage(3, 8'hFF, 8'h44, 0, 3, 1'b1);
    arm();
    smp(8'h22, "R4 order level0"); smp(8'h33, "R4 order level0"); smp(8'h44, "R4 order level0");
    smp(8'h11, "R6 no action stage");
    smp(8'h33, "R4 order level1"); smp(8'h22, "R6 no action stage");
    smp(8'h44, "R4 order level2"); smp(8'h33, "R6 no action stage");
    smp(8'h44, "R4 final stage start");
    smp(8'h44, "R10 ignored after start");
    smp(8'h11, "R10 ignored after start");
    arm();
    smp(8'h11, "R4 rerun"); smp(8'h22, "R4 rerun"); smp(8'h33, "R4 rerun");
    arm_i = 1'b1; sample_en_i = 1'b1; sample_i = 8'h44;
    @(posedge clk_i); #1;
    chk(start_o, 1'b0, "R10 arm beats sample");
    @(negedge clk_i); arm_i = 1'b0; sample_en_i = 1'b0;
    m_armed = 1'b1; m_lvl = 0; m_pend = 1'b0;
    smp(8'h44, "R10 level cleared by arm");

    // R5: two stages on level 0; lowest index taken
    set_stage(0, 8'h0F, 8'h05, 0, 0, 1'b0);
    set_stage(1, 8'h0F, 8'h05, 0, 0, 1'b1);
    set_stage(2, 8'hFF, 8'hAA, 0, 1, 1'b1);
    arm();
    smp(8'hF5, "R5 lower index wins");
    smp(8'h05, "R5 higher stage off level");
    smp(8'hAA, "R5 next level start");

    // R7/R11: delay with idle cycles in between
    set_stage(0, 8'hFF, 8'h77, 3, 0, 1'b1);
    set_stage(1, 8'hFF, 8'h00, 0, 3, 1'b0);
    set_stage(2, 8'hFF, 8'h00, 0, 3, 1'b0);
    arm();
    smp(8'h77, "R7 delay load");
    idle(4, "R11 idle no count");
    smp(8'h00, "R7 delay count");
    idle(2, "R11 idle no count");
    smp(8'h00, "R7 delay count");
    smp(8'h12, "R7 delay expiry start");
    // long delay
    set_stage(0, 8'hFF, 8'h77, 300, 0, 1'b1);
    arm();
    smp(8'h77, "R7 long delay load");
    for (int i = 1; i <= 300; i++) smp(rnd()[7:0], "R7 long delay");

    // R8: pending delay blocks another passing stage
    set_stage(0, 8'hFF, 8'h10, 2, 0, 1'b0);
    set_stage(1, 8'hFF, 8'h20, 0, 0, 1'b1);
    set_stage(2, 8'hFF, 8'h30, 0, 1, 1'b1);
    arm();
    smp(8'h10, "R8 pend start");
    smp(8'h20, "R8 blocked while pending");
    smp(8'h20, "R8 blocked while pending");
    smp(8'h20, "R8 level moved on");
    smp(8'h30, "R8 next stage start");

    // R10: arm drops a pending delay
    set_stage(0, 8'hFF, 8'h66, 5, 0, 1'b1);
    arm();
    smp(8'h66, "R10 pend");
    smp(8'h00, "R10 pend"); smp(8'h00, "R10 pend");
    arm();
    for (int i = 0; i < 6; i++) smp(8'h01, "R10 pending dropped");
    smp(8'h66, "R10 reload");
    for (int i = 0; i < 5; i++) smp(8'h01, "R10 reload count");

    // pseudo-random sweep on narrow masks
    for (int t = 0; t < 300; t++) begin
      for (int s = 0; s < 4; s++)
        set_stage(s, {6'h0, rnd()[1:0]}, {6'h0, rnd()[1:0]}, int'(rnd()[1:0]),
                  int'(rnd()[1:0]), rnd()[0]);
      arm();
      for (int i = 0; i < 40; i++) begin
        if (rnd()[2:0] == 3'd0) idle(1, "R11 random idle");
        smp({6'h0, rnd()[1:0]}, "R4 R5 R7 R8 random sequence");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule